// File: doc/BRIEF.md
# Memory Recurrence Loop Engine with Hazard Interlock

The engine runs a fixed loop over a 256-word on-chip memory. On a start request it samples a 32-bit scalar. It then performs 255 iterations with index i = 0 to 254. Each iteration reads the word at address i, multiplies it by the scalar, and writes the low 32 bits of the product to address i+1. The memory is not reset and keeps its contents from one invocation to the next.

Iteration i+1 reads the word that iteration i writes. The engine therefore compares the address it is about to read against the address of the write still in flight, and holds the read back until that write has committed. The memory has a one-cycle read latency and the multiplier has two pipeline stages, so a new iteration starts every four cycles.

An elaboration parameter `FORWARD` enables a bypass. With the bypass, the first iteration reads memory and every later iteration takes the previous product as its operand directly. Iterations then start every two cycles. Memory writes and the returned value are the same in both variants.

A load port gives access to the memory while the engine is idle, for preloading words and reading them back.

Top module: `mrec_engine`

## Requirements
- R1: After a synchronous active-low reset, `done` is low and `result` is zero.
- R2: A run writes mem[k+1] = mem[k] * scalar for k from 0 to 254, in ascending k, keeping the low 32 bits of the signed product. Address 0 is never written by a run.
- R3: After `done`, `result` holds the operand of the last iteration, which is the word at address 254 after the run.
- R4: With FORWARD = 0, iterations start every 4 cycles. `done` is high in the 1021st cycle after the cycle in which `start` is sampled.
- R5: With FORWARD = 0, no read of iteration i+1 is issued before the write of iteration i has committed. Results depend only on address 0, whatever values addresses 1 to 255 held before the run.
- R6: With FORWARD = 1, iterations start every 2 cycles. `done` is high in the 513th cycle after the cycle in which `start` is sampled. Memory contents and `result` are identical to those of FORWARD = 0.
- R7: `done` is a single-cycle pulse in the cycle after the final write, once per run.
- R8: While a run is in progress, `start` and `scalar_a` are ignored. The run is not restarted and its timing and values are unchanged.
- R9: While idle, `ld_we` writes `ld_wdata` to word address `ld_addr`. `ld_rdata` shows the word at the `ld_addr` of the previous cycle, so the read latency is one cycle. Load-port writes issued during a run are ignored.
- R10: Memory contents persist across runs. A second run without preloading starts from the address 0 word left by the earlier runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| scalar_a | input | 32 | Multiplier scalar, sampled with start |
| done | output | 1 | One-cycle pulse when the run has finished |
| result | output | 32 | Operand of the final iteration |
| ld_we | input | 1 | Load-port write enable (idle only) |
| ld_addr | input | 8 | Load-port word address |
| ld_wdata | input | 32 | Load-port write data |
| ld_rdata | output | 32 | Word read at the previous cycle's address |

## Verification
The following properties are checked on every cycle:
- no read issues while the previous iteration's write is outstanding, and reads are never closer together than the interlock spacing;
- `done` lasts one cycle and comes only after all 255 writes;
- the scalar stays frozen while a run is active;
- no write reaches address 0 during a run.

The bench scenarios are what show the arithmetic, the exact run length of each variant, and that preloaded junk in addresses 1 to 255 cannot leak into the results. They also show that a restart attempt or a load-port write during a run is ignored, and that memory contents carry over between runs.

// File: rtl/mrec_pkg.sv
// Package: shared types and helpers for the memory recurrence engine.
// Assumes: nothing beyond plain SystemVerilog.
package mrec_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    // Cycles between iteration starts for a given variant and multiplier latency.
    function automatic int iter_spacing(input bit fwd, input int mul_lat);
        return fwd ? mul_lat : mul_lat + 2;
    endfunction

endpackage

// File: rtl/mrec_mem.sv
// Module: single-read, single-write word memory with a registered read.
// Assumes: contents are not reset. A read of an address being written in
// the same cycle returns the old word; the engine's interlock never relies
// on that case.
module mrec_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] words [DEPTH];

    // Write port commit and registered read.
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
        rdata <= words[raddr];
    end

endmodule

// File: rtl/mrec_mul.sv
// Module: pipelined multiplier keeping the low DW bits of the product.
// Assumes: the low half of a two's-complement product does not depend on
// signedness, so one unsigned multiply serves signed operands. LAT >= 1.
module mrec_mul #(
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic          out_valid,
    output logic [DW-1:0] product
);

    logic [DW-1:0] prod_lo;
    logic [DW-1:0] d_q [LAT];
    logic [LAT-1:0] v_q;

    // Low half of the product.
    assign prod_lo = op_a * op_b;

    // Shift the product and its valid flag through LAT stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int s = 0; s < LAT; s++) d_q[s] <= '0;
        end else begin
            v_q[0] <= in_valid;
            d_q[0] <= prod_lo;
            for (int s = 1; s < LAT; s++) begin
                v_q[s] <= v_q[s-1];
                d_q[s] <= d_q[s-1];
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign product   = d_q[LAT-1];

endmodule

// File: rtl/mrec_ctrl.sv
// Module: loop sequencer. It issues reads, feeds the multiplier, retires
// writes to the next address and signals completion.
// Assumes: the memory read latency is 1 cycle and the multiplier latency is
// MUL_LAT. With FWD = 0 a read waits while its address matches the pending
// write. With FWD = 1 only the first iteration reads and later operands
// come from the product.
module mrec_ctrl
    import mrec_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int MUL_LAT = 2,
    parameter bit FWD     = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] scalar_a,
    input  logic [DW-1:0] rd_data,
    input  logic          prod_valid,
    input  logic [DW-1:0] product,
    output logic          busy,
    output logic [AW-1:0] rd_addr,
    output logic          mul_in_valid,
    output logic [DW-1:0] mul_op,
    output logic [DW-1:0] mul_scalar,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic [DW-1:0] result
);

    localparam int CW   = AW + 1;
    localparam int ITER = (1 << AW) - 1;
    localparam int II   = iter_spacing(FWD, MUL_LAT);
    localparam logic [CW-1:0] LAST = CW'(ITER);

    run_st_e       st;
    logic [DW-1:0] a_q;
    logic [CW-1:0] rd_cnt, op_cnt, wr_cnt;
    logic          rd_v_q, rd_issue, last_wr;
    logic [DW-1:0] result_q;
    logic          done_q;

    assign busy       = (st == ST_RUN);
    assign rd_addr    = rd_cnt[AW-1:0];
    assign mul_scalar = a_q;
    assign wr_en      = prod_valid;
    assign wr_addr    = wr_cnt[AW-1:0] + AW'(1);
    assign wr_data    = product;
    assign last_wr    = prod_valid && (wr_cnt == LAST - CW'(1));

    if (FWD) begin : g_bypass
        // Single read for iteration 0, then each product feeds the next iteration.
        assign rd_issue     = busy && (rd_cnt == '0);
        assign mul_in_valid = rd_v_q || (prod_valid && (op_cnt < LAST));
        assign mul_op       = rd_v_q ? rd_data : product;
    end else begin : g_interlock
        logic          pend_q;
        logic [AW-1:0] pend_addr_q;
        logic          hazard;
        logic [7:0]    gap_q;

        // Hold the read while its address matches the outstanding write.
        assign hazard       = pend_q && (pend_addr_q == rd_cnt[AW-1:0]);
        assign rd_issue     = busy && (rd_cnt < LAST) && !hazard;
        assign mul_in_valid = rd_v_q;
        assign mul_op       = rd_data;

        // Track the write target of the iteration in flight.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q      <= 1'b0;
                pend_addr_q <= '0;
            end else if (rd_issue) begin
                pend_q      <= 1'b1;
                pend_addr_q <= rd_cnt[AW-1:0] + AW'(1);
            end else if (prod_valid) begin
                pend_q      <= 1'b0;
            end
        end

        // Cycles since the last read issue, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n)              gap_q <= 8'hFF;
            else if (rd_issue)       gap_q <= '0;
            else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
        end

        // R5
        rd_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_issue |-> (wr_cnt == rd_cnt));

        // R4
        issue_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_issue && rd_cnt != '0) |-> (gap_q >= 8'(II - 1)));
    end

    // Run state, scalar capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            a_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st == ST_IDLE && start) begin
                st  <= ST_RUN;
                a_q <= scalar_a;
            end else if (st == ST_RUN && last_wr) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    // Iteration counters for reads, multiplier inputs and writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            op_cnt <= '0;
            wr_cnt <= '0;
            rd_v_q <= 1'b0;
        end else begin
            rd_v_q <= rd_issue;
            if (st == ST_IDLE && start) begin
                rd_cnt <= '0;
                op_cnt <= '0;
                wr_cnt <= '0;
            end else begin
                if (rd_issue)     rd_cnt <= rd_cnt + CW'(1);
                if (mul_in_valid) op_cnt <= op_cnt + CW'(1);
                if (prod_valid)   wr_cnt <= wr_cnt + CW'(1);
            end
        end
    end

    // Keep the operand of the latest iteration as the returned value.
    always_ff @(posedge clk) begin
        if (!rst_n)            result_q <= '0;
        else if (mul_in_valid) result_q <= mul_op;
    end

    assign done   = done_q;
    assign result = result_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_cnt == LAST));

    // R8
    scalar_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(a_q));

endmodule

// File: rtl/mrec_engine.sv
// Module: top of the memory recurrence engine. It joins the memory, the
// multiplier and the sequencer, and hands the memory ports to the load port
// while idle.
// Assumes: the load port is used only between runs; its writes during a run
// are dropped.
module mrec_engine #(
    parameter int DW      = 32,
    parameter int DEPTH   = 256,
    parameter int MUL_LAT = 2,
    parameter bit FORWARD = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [DW-1:0]            scalar_a,
    output logic                     done,
    output logic [DW-1:0]            result,
    input  logic                     ld_we,
    input  logic [$clog2(DEPTH)-1:0] ld_addr,
    input  logic [DW-1:0]            ld_wdata,
    output logic [DW-1:0]            ld_rdata
);

    localparam int AW = $clog2(DEPTH);

    logic          busy;
    logic [AW-1:0] loop_raddr, loop_waddr, mem_raddr, mem_waddr;
    logic          loop_we, mem_we;
    logic [DW-1:0] loop_wdata, mem_wdata, mem_rdata;
    logic          mul_in_valid, prod_valid;
    logic [DW-1:0] mul_op, mul_scalar, product;

    // Memory port ownership: the loop while busy, the load port otherwise.
    always_comb begin
        if (busy) begin
            mem_we    = loop_we;
            mem_waddr = loop_waddr;
            mem_wdata = loop_wdata;
            mem_raddr = loop_raddr;
        end else begin
            mem_we    = ld_we;
            mem_waddr = ld_addr;
            mem_wdata = ld_wdata;
            mem_raddr = ld_addr;
        end
    end

    assign ld_rdata = mem_rdata;

    mrec_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    mrec_mul #(.DW(DW), .LAT(MUL_LAT)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mul_in_valid),
        .op_a      (mul_op),
        .op_b      (mul_scalar),
        .out_valid (prod_valid),
        .product   (product)
    );

    mrec_ctrl #(.DW(DW), .AW(AW), .MUL_LAT(MUL_LAT), .FWD(FORWARD)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .scalar_a     (scalar_a),
        .rd_data      (mem_rdata),
        .prod_valid   (prod_valid),
        .product      (product),
        .busy         (busy),
        .rd_addr      (loop_raddr),
        .mul_in_valid (mul_in_valid),
        .mul_op       (mul_op),
        .mul_scalar   (mul_scalar),
        .wr_en        (loop_we),
        .wr_addr      (loop_waddr),
        .wr_data      (loop_wdata),
        .done         (done),
        .result       (result)
    );

    // R2
    no_addr0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_waddr != '0));

endmodule

// File: tb/test_mrec_engine.sv
// Bench: directed scenarios on two instances (interlocked and bypassed)
// sharing all inputs.
module test_mrec_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] scalar_a = '0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_wdata = '0;
    logic        done_n, done_f;
    logic [31:0] result_n, result_f, rdata_n, rdata_f;

    int n_cmp = 0;
    int n_bad = 0;
    int wd_cycles = 0;

    always #5 clk = ~clk;

    mrec_engine #(.FORWARD(1'b0)) i_mrec_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar_a(scalar_a),
        .done(done_n), .result(result_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_rdata(rdata_n));

    mrec_engine #(.FORWARD(1'b1)) i_mrec_engine_fwd (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar_a(scalar_a),
        .done(done_f), .result(result_f), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_rdata(rdata_f));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] chain(input logic [31:0] x, input logic [31:0] a, input int k);
        logic [31:0] v = x;
        for (int j = 0; j < k; j++) v = v * a;
        return v;
    endfunction

    task automatic ld_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = addr; ld_wdata = data;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic ld_read(input logic [7:0] addr, output logic [31:0] vn, output logic [31:0] vf);
        @(negedge clk);
        ld_addr = addr;
        @(negedge clk);
        vn = rdata_n; vf = rdata_f;
    endtask

    task automatic preload(input logic [31:0] x);
        for (int k = 255; k >= 0; k--)
            ld_write(8'(k), (k == 0) ? x : (32'hDEAD_0000 | 32'(k)));
    endtask

    // Memory image after a run: mem[k] = x * a^k.
    task automatic check_mem(input logic [31:0] x, input logic [31:0] a, input string tag);
        logic [31:0] vn, vf, e;
        for (int k = 0; k < 256; k++) begin
            ld_read(8'(k), vn, vf);
            e = chain(x, a, k);
            check({tag, " mem non-fwd"}, vn, e);
            check({tag, " mem fwd"}, vf, e);
        end
    endtask

    // One run on both instances, optionally with start and load-port disturbances.
    task automatic run(input logic [31:0] a, input bit disturb, input logic [31:0] x, input string tag);
        int lat_n = 0, lat_f = 0, hi_n = 0, hi_f = 0;
        @(negedge clk);
        start = 1'b1; scalar_a = a;
        @(negedge clk);
        start = 1'b0;
        for (int cnt = 1; cnt <= 1040; cnt++) begin
            if (done_n) begin hi_n++; if (lat_n == 0) lat_n = cnt; end
            if (done_f) begin hi_f++; if (lat_f == 0) lat_f = cnt; end
            if (disturb && cnt == 100) begin start = 1'b1; scalar_a = 32'd9; end
            if (disturb && cnt == 101) start = 1'b0;
            if (disturb && cnt == 200) begin ld_we = 1'b1; ld_addr = 8'd0; ld_wdata = 32'hBAD0_BAD0; end
            if (disturb && cnt == 201) ld_we = 1'b0;
            @(negedge clk);
        end
        check({tag, " R4 latency non-fwd"}, 32'(lat_n), 32'd1021);
        check({tag, " R6 latency fwd"}, 32'(lat_f), 32'd513);
        check({tag, " R7 done pulses non-fwd"}, 32'(hi_n), 32'd1);
        check({tag, " R7 done pulses fwd"}, 32'(hi_f), 32'd1);
        check({tag, " R3 result non-fwd"}, result_n, chain(x, a, 254));
        check({tag, " R6 result fwd"}, result_f, chain(x, a, 254));
    endtask

    task automatic t_reset;
        check("R1 done non-fwd", 32'(done_n), 32'd0);
        check("R1 done fwd", 32'(done_f), 32'd0);
        check("R1 result non-fwd", result_n, 32'd0);
        check("R1 result fwd", result_f, 32'd0);
    endtask

    task automatic t_load_port;
        logic [31:0] vn, vf;
        ld_write(8'd17, 32'h1234_5678);
        ld_write(8'd255, 32'hCAFE_0001);
        ld_read(8'd17, vn, vf);
        check("R9 readback 17 non-fwd", vn, 32'h1234_5678);
        check("R9 readback 17 fwd", vf, 32'h1234_5678);
        ld_read(8'd255, vn, vf);
        check("R9 readback 255 non-fwd", vn, 32'hCAFE_0001);
        check("R9 readback 255 fwd", vf, 32'hCAFE_0001);
    endtask

    // R2 R5: junk in addresses 1..255 must not reach the results.
    task automatic t_basic;
        preload(32'd5);
        run(32'd3, 1'b0, 32'd5, "R5 basic");
        check_mem(32'd5, 32'd3, "R2 basic");
    endtask

    // R8 R9: restart attempt and load-port write during the run are ignored.
    task automatic t_disturb;
        preload(32'd7);
        run(32'hFFFF_FFFF, 1'b1, 32'd7, "R8 disturb");
        check_mem(32'd7, 32'hFFFF_FFFF, "R9 disturb");
    endtask

    // R10: no preload, address 0 carries over from the previous run.
    task automatic t_persist;
        run(32'd0, 1'b0, 32'd7, "R10 persist");
        check_mem(32'd7, 32'd0, "R10 persist");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load_port;
        t_basic;
        t_disturb;
        t_persist;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd_cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule